// File: doc/BRIEF.md
# Twin constant-product shift-add unit

This block multiplies one signed input word by two fixed constants, 29 and 43, in the same cycle, without any general multiplier. Both products are built from a single shared odd partial term, seven times the input. That term is formed once and reused. Every left shift is plain wiring, so the whole arithmetic cost is three adders or subtractors: 7x = 8x − x, then 29x = 4·7x + x, then 43x = 29x + 2·7x.

The input is two's complement. Each operand is sign-extended to the width of the operation before it is added or subtracted. Each product is `IN_W + 6` bits wide, which is enough to hold 43x for every input value, the most negative one included. A parameter selects one of two output modes. In the first, an output register captures the products on a valid input. In the second, the products and the valid flag pass straight through without registers.

Top module: `dual_const_mul`

## Requirements
- R1: `prod29` equals 29 × `x_in`, reading `x_in` as a two's-complement value and `prod29` as a two's-complement value of `IN_W + 6` bits.
- R2: `prod43` equals 43 × `x_in` under the same encoding.
- R3: Neither product wraps, for any input from −2^(IN_W−1) to 2^(IN_W−1)−1. For a nonzero input, the sign bit of each product equals the sign bit of `x_in`.
- R4: With `REG_OUT = 1`, the products of an input sampled with `in_valid` high appear at the outputs after that clock edge, and `out_valid` is high in that same following cycle.
- R5: With `REG_OUT = 1`, a rising edge with `in_valid` low leaves `prod29` and `prod43` unchanged and drives `out_valid` low, whatever value `x_in` has.
- R6: With `REG_OUT = 1`, while `rst_n` is low, `out_valid`, `prod29` and `prod43` are all zero.
- R7: With `REG_OUT = 0`, the products follow `x_in` in the same cycle, with no clock edge in between, and `out_valid` equals `in_valid`.
- R8: An input of 5 yields 145 on `prod29` and 215 on `prod43`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `x_in` as a word to be multiplied |
| x_in | input | IN_W | Signed multiplicand |
| out_valid | output | 1 | Marks the products as fresh |
| prod29 | output | IN_W+6 | Signed product 29 × x |
| prod43 | output | IN_W+6 | Signed product 43 × x |

## Verification
A fault in the shared seven-times term affects both products in the same cycle, because 43x is built on top of 29x. A shift or sign error therefore shows on most inputs of a full sweep, and the wrong value reaches the ports on the first valid word that carries it. Sign-extension faults show only on negative inputs and at the extreme input values, so the sweep covers the whole signed range on both output modes. A fault in the output register shows one edge after the stimulus: either the products change during an idle cycle, or `out_valid` fails to follow the previous cycle's `in_valid`.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    // Extra product bits over the input width: 43 < 2^6 keeps every product in range.
    localparam int GROWTH = 6;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

endpackage

// File: rtl/dcm_addsub.sv
module dcm_addsub
    import dcm_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int Y_W = 14
) (
    input  logic signed [A_W-1:0] a,
    input  logic signed [B_W-1:0] b,
    input  addsub_op_e            op,
    output logic signed [Y_W-1:0] y
);

    logic signed [Y_W-1:0] a_ext;
    logic signed [Y_W-1:0] b_ext;

    // Sign-extend both operands to the result width, then add or subtract.
    always_comb begin
        a_ext = Y_W'(a);
        b_ext = Y_W'(b);
        if (op == OP_SUB) begin
            y = a_ext - b_ext;
        end else begin
            y = a_ext + b_ext;
        end
    end

endmodule

// File: rtl/dcm_shared_core.sv
module dcm_shared_core
    import dcm_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + GROWTH
) (
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] p29,
    output logic signed [OUT_W-1:0] p43
);

    localparam int SEV_W = IN_W + 3;   // holds 7x for any signed x
    localparam int SH2_W = SEV_W + 2;
    localparam int SH1_W = SEV_W + 1;

    logic signed [SEV_W-1:0] x_sh3;
    logic signed [SEV_W-1:0] seven_x;
    logic signed [SH2_W-1:0] seven_sh2;
    logic signed [SH1_W-1:0] seven_sh1;

    // Shifts are wiring only.
    assign x_sh3     = {x, 3'b000};
    assign seven_sh2 = {seven_x, 2'b00};
    assign seven_sh1 = {seven_x, 1'b0};

    // Operation 1: 7x = 8x - x
    dcm_addsub #(.A_W(SEV_W), .B_W(IN_W), .Y_W(SEV_W)) u_sev (
        .a (x_sh3),
        .b (x),
        .op(OP_SUB),
        .y (seven_x)
    );

    // Operation 2: 29x = 28x + x
    dcm_addsub #(.A_W(SH2_W), .B_W(IN_W), .Y_W(OUT_W)) u_p29 (
        .a (seven_sh2),
        .b (x),
        .op(OP_ADD),
        .y (p29)
    );

    // Operation 3: 43x = 29x + 14x
    dcm_addsub #(.A_W(OUT_W), .B_W(SH1_W), .Y_W(OUT_W)) u_p43 (
        .a (p29),
        .b (seven_sh1),
        .op(OP_ADD),
        .y (p43)
    );

    localparam logic signed [OUT_W-1:0] K29 = OUT_W'(29);
    localparam logic signed [OUT_W-1:0] K43 = OUT_W'(43);
    logic signed [OUT_W-1:0] x_wide;
    assign x_wide = OUT_W'(x);

    always_comb begin
        a_r1_prod29: assert (p29 == x_wide * K29);
        a_r2_prod43: assert (p43 == x_wide * K43);
        if (x != '0) begin
            a_r3_no_overflow: assert (p43[OUT_W-1] == x[IN_W-1] && p29[OUT_W-1] == x[IN_W-1]);
        end
    end

endmodule

// File: rtl/dcm_out_stage.sv
module dcm_out_stage #(
    parameter int W       = 14,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] p29_i,
    input  logic [W-1:0] p43_i,
    output logic         vld_o,
    output logic [W-1:0] p29_o,
    output logic [W-1:0] p43_o
);

    generate
        if (REG_OUT) begin : g_reg
            typedef struct packed {
                logic         vld;
                logic [W-1:0] p29;
                logic [W-1:0] p43;
            } stage_t;

            stage_t st_d;
            stage_t st_q;

            always_comb begin
                st_d     = st_q;
                st_d.vld = vld_i;
                if (vld_i) begin
                    st_d.p29 = p29_i;
                    st_d.p43 = p43_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign vld_o = st_q.vld;
            assign p29_o = st_q.p29;
            assign p43_o = st_q.p43;

            a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                vld_i |=> (vld_o && p29_o == $past(p29_i) && p43_o == $past(p43_i)));

            a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !vld_i |=> (!vld_o && $stable(p29_o) && $stable(p43_o)));

            always_comb begin
                if (!rst_n) begin
                    a_r6_reset_clear: assert (!vld_o && p29_o == '0 && p43_o == '0);
                end
            end
        end else begin : g_comb
            assign vld_o = vld_i;
            assign p29_o = p29_i;
            assign p43_o = p43_i;

            a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_o == vld_i) && (p29_o == p29_i) && (p43_o == p43_i));
        end
    endgenerate

endmodule

// File: rtl/dual_const_mul.sv
module dual_const_mul
    import dcm_pkg::*;
#(
    parameter int  IN_W    = 8,
    parameter bit  REG_OUT = 1'b1,
    localparam int OUT_W   = IN_W + GROWTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  x_in,
    output logic             out_valid,
    output logic [OUT_W-1:0] prod29,
    output logic [OUT_W-1:0] prod43
);

    logic signed [OUT_W-1:0] core29;
    logic signed [OUT_W-1:0] core43;

    dcm_shared_core #(.IN_W(IN_W), .OUT_W(OUT_W)) u_core (
        .x  ($signed(x_in)),
        .p29(core29),
        .p43(core43)
    );

    dcm_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(in_valid),
        .p29_i(core29),
        .p43_i(core43),
        .vld_o(out_valid),
        .p29_o(prod29),
        .p43_o(prod43)
    );

endmodule

// File: tb/test_dual_const_mul.sv
`timescale 1ns/1ps
module test_dual_const_mul;

    localparam int IN_W  = 8;
    localparam int OUT_W = IN_W + 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  x_in = '0;
    logic             vr, vc;
    logic [OUT_W-1:0] r29, r43, c29, c43;

    int checks = 0;
    int errors = 0;
    int exp_r29 = 0;
    int exp_r43 = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_const_mul #(.IN_W(IN_W), .REG_OUT(1'b1)) i_dual_const_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
        .out_valid(vr), .prod29(r29), .prod43(r43)
    );

    dual_const_mul #(.IN_W(IN_W), .REG_OUT(1'b0)) i_dual_const_mul_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
        .out_valid(vc), .prod29(c29), .prod43(c43)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sv(input logic [OUT_W-1:0] v);
        return int'($signed(v));
    endfunction

    // Drive one word at the falling edge, check the combinational instance,
    // then check the registered instance just after the next rising edge.
    task automatic step(input int xv, input logic v);
        @(negedge clk);
        x_in     = IN_W'(xv);
        in_valid = v;
        #1;
        check("R7 comb prod29", sv(c29), 29 * xv);
        check("R7 comb prod43", sv(c43), 43 * xv);
        check("R7 comb valid", int'(vc), int'(v));
        @(posedge clk);
        #1;
        if (v) begin
            exp_r29 = 29 * xv;
            exp_r43 = 43 * xv;
        end
        check(v ? "R1 reg prod29" : "R5 hold prod29", sv(r29), exp_r29);
        check(v ? "R2 reg prod43" : "R5 hold prod43", sv(r43), exp_r43);
        check(v ? "R4 out_valid high" : "R5 out_valid low", int'(vr), int'(v));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R6: reset state, even with a valid word presented
        @(negedge clk);
        in_valid = 1'b1;
        x_in     = 8'd77;
        @(posedge clk);
        #1;
        check("R6 reset out_valid", int'(vr), 0);
        check("R6 reset prod29", sv(r29), 0);
        check("R6 reset prod43", sv(r43), 0);
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;

        // R8: the worked example
        step(5, 1'b1);
        check("R8 prod29 for 5", sv(r29), 145);
        check("R8 prod43 for 5", sv(r43), 215);

        // R3: both ends of the signed range
        step(-128, 1'b1);
        check("R3 min prod43", sv(r43), -5504);
        step(127, 1'b1);
        check("R3 max prod43", sv(r43), 5461);

        // R5: idle cycles with changing input must not disturb the registers
        step(-1, 1'b0);
        step(100, 1'b0);
        step(-77, 1'b0);

        // R1, R2: exhaustive sweep of every signed input
        for (int i = -128; i < 128; i++) begin
            step(i, 1'b1);
            if (i != 0) begin
                check("R3 sign prod29", int'(r29[OUT_W-1]), (i < 0) ? 1 : 0);
                check("R3 sign prod43", int'(r43[OUT_W-1]), (i < 0) ? 1 : 0);
            end
        end

        // R4, R5: alternating valid and idle words
        for (int i = 0; i < 40; i++) begin
            step((i * 37) % 256 - 128, (i % 3) != 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule